// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a physical address by walking a radix page table held in memory. A request carries the virtual address, the access kind (fetch, load or store), the effective privilege, the supervisor-may-touch-user flag, the make-executable-readable flag, a translation mode and the page number of the root table. The walker then reads one page table entry at a time over a simple request/response memory port, moving from the most significant index level down. It applies the leaf legality and permission rules and writes back the accessed and dirty bits when they need to change. It returns either a physical address with read, write and execute permissions or a fault.

Five modes are supported: bare pass-through, a two-level scheme with 4-byte entries and 10-bit indices, and three-, four- and five-level schemes with 8-byte entries and 9-bit indices. A leaf found above the last level maps a superpage. The low virtual page bits under that leaf are merged into the physical page number. The walker handles one translation at a time and keeps one memory operation in flight.

Top module: `pgwalk_top`

## Requirements
- R1: When the mode is bare (code 0) or the privilege code is 2 or 3 (machine path), the result is the virtual address truncated to the physical width, with R, W and X all granted, no fault and no memory access.
- R2: Mode codes are 1 (2 levels, 10-bit index, 4-byte entry), 2, 3 and 4 (3, 4 and 5 levels, 9-bit index, 8-byte entry). Codes 5 to 7 fault with no memory access. Each entry is read at base plus index times entry size, starting at root page times 4096 and the top level, so a 4 KiB leaf takes exactly as many reads as the mode has levels.
- R3: Outside the 2-level mode, all virtual address bits above the implemented width (39, 48 or 57) must match its top bit, or the access faults with no memory read. The 2-level mode ignores virtual address bits 63 to 32.
- R4: PTE bits are V=0, R=1, W=2, X=3, U=4, A=6, D=7, with the page number from bit 10 up. V clear faults. V set with R, W and X clear points to the next table at page number times 4096. Such a pointer at the last level faults.
- R5: A leaf with W set and R clear (W alone, or W with X) faults.
- R6: Privilege codes are 0 (user) and 1 (supervisor). A U leaf faults unless the privilege is user, or the access is not a fetch and the supervisor-may-touch-user flag is set. A non-U leaf faults unless the privilege is supervisor.
- R7: A superpage leaf whose page number has any nonzero bit below the level's shift (level times index width) faults.
- R8: Access codes are 0 fetch, 1 load and 2 store. A load needs R, or X with the make-executable-readable flag. A store needs W. A fetch needs X.
- R9: On a legal leaf with A clear, or with D clear on a store, the entry is written back with A set (and D for stores) before completion. Otherwise no write occurs.
- R10: The physical address is (leaf page number OR the virtual page bits below the level's shift) times 4096 plus the 12-bit page offset.
- R11: Granted permissions are: R if R, or X with make-executable-readable; W if W and (store or D); X if X.
- R12: An error response on any entry read or write-back faults.
- R13: After reset the walker is ready and idle. Completion is a one-cycle pulse. At most one memory request is issued per cycle and none on consecutive cycles. A fault reports a zero address and no permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Start a translation (accepted when reqReady) |
| reqReady | output | 1 | Walker idle |
| reqVa | input | XLEN | Virtual address |
| reqAcc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| reqPriv | input | 2 | Effective privilege: 0 user, 1 supervisor, 2/3 machine path |
| reqSum | input | 1 | Supervisor may access user pages |
| reqMxr | input | 1 | Executable pages readable |
| reqMode | input | 3 | Translation mode code |
| reqRootPpn | input | PA_W-12 | Root table page number |
| doneValid | output | 1 | One-cycle completion pulse |
| doneFault | output | 1 | Translation faulted |
| donePa | output | PA_W | Physical address |
| doneR | output | 1 | Read granted |
| doneW | output | 1 | Write granted |
| doneX | output | 1 | Execute granted |
| memReqValid | output | 1 | Memory request strobe |
| memReqWrite | output | 1 | Request is an entry write-back |
| memWide | output | 1 | 8-byte entry (else 4-byte) |
| memAddr | output | PA_W | Entry byte address |
| memWdata | output | 64 | Write-back data |
| memRspValid | input | 1 | Memory response strobe |
| memRspErr | input | 1 | Memory response error |
| memRspData | input | 64 | Entry read data (4-byte entries zero-extended) |

## Verification
On every cycle the assertions check the port-level protocol. Memory requests never come back to back and never arrive while the walker reports ready. Entry addresses are aligned to the entry size, and every write-back carries the accessed bit. Completion lasts exactly one cycle, a fault carries no address or permissions, and a granted write always comes with a granted read. The walk itself can only be judged against the bench's page tables: the read counts per mode, superpage address merging, each leaf legality rule, the privilege and flag interactions, bus errors, and the accessed/dirty write-back left in memory.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int PG_OFF = 12;
  localparam int PTE_W  = 64;

  localparam logic [2:0] MODE_BARE = 3'd0;
  localparam logic [2:0] MODE_SV32 = 3'd1;
  localparam logic [2:0] MODE_SV39 = 3'd2;
  localparam logic [2:0] MODE_SV48 = 3'd3;
  localparam logic [2:0] MODE_SV57 = 3'd4;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd2;

  // control -> datapath
  typedef struct packed {
    logic latchReq;
    logic latchPte;
    logic descend;
    logic finOk;
    logic finFault;
    logic finBare;
  } walkStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic passThru;
    logic badReq;
    logic pteFault;
    logic isPtr;
    logic lastLevel;
    logic needWrite;
  } walkStatus_t;

  // number of table levels per mode, 0 for an unsupported code
  function automatic logic [2:0] modeDepth(input logic [2:0] m);
    case (m)
      MODE_SV32: modeDepth = 3'd2;
      MODE_SV39: modeDepth = 3'd3;
      MODE_SV48: modeDepth = 3'd4;
      MODE_SV57: modeDepth = 3'd5;
      default:   modeDepth = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/pgwalk_dpath.sv
module pgwalk_dpath
  import pgwalk_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int PA_W = 56
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  walkStrobe_t              stb,
  input  logic [XLEN-1:0]          reqVa,
  input  logic [1:0]               reqAcc,
  input  logic [1:0]               reqPriv,
  input  logic                     reqSum,
  input  logic                     reqMxr,
  input  logic [2:0]               reqMode,
  input  logic [PA_W-PG_OFF-1:0]   reqRootPpn,
  input  logic [PTE_W-1:0]         memRspData,
  output walkStatus_t              sts,
  output logic [PA_W-1:0]          memAddr,
  output logic [PTE_W-1:0]         memWdata,
  output logic                     memWide,
  output logic                     doneFault,
  output logic [PA_W-1:0]          donePa,
  output logic                     doneR,
  output logic                     doneW,
  output logic                     doneX
);
  localparam int PPN_W = PA_W - PG_OFF;
  localparam int VPN_W = XLEN - PG_OFF;

  logic [XLEN-1:0]  vaQ;
  logic [1:0]       accQ, privQ;
  logic             sumQ, mxrQ;
  logic [2:0]       modeQ, lvlQ;
  logic [PA_W-1:0]  baseQ;
  logic [PTE_W-1:0] pteQ;

  logic             sv32, canon, isStore, isFetch, isLoad;
  logic [2:0]       levels;
  logic [3:0]       idxBits;
  logic [6:0]       vaBits;
  logic [5:0]       shiftAmt;
  logic [XLEN-1:0]  hiMask, hiBits, vaEff;
  logic [VPN_W-1:0] vpn, idxMask, idx;
  logic [PTE_W-1:0] pteData, pteNew;
  logic [PPN_W-1:0] ppn, lowMask;
  logic             fV, fR, fW, fX, fU, fA, fD;
  logic             misaligned, uBad, sBad, accBad, leafBad;
  logic [PA_W-1:0]  leafPa;

  always_comb begin
    sv32     = (modeQ == MODE_SV32);
    levels   = modeDepth(modeQ);
    idxBits  = sv32 ? 4'd10 : 4'd9;
    vaBits   = 7'(PG_OFF) + 7'(levels) * 7'd9;
    hiMask   = ~((XLEN'(1) << (vaBits - 7'd1)) - XLEN'(1));
    hiBits   = vaQ & hiMask;
    canon    = (hiBits == '0) || (hiBits == hiMask);
    vaEff    = sv32 ? XLEN'(vaQ[31:0]) : vaQ;
    vpn      = vaEff[XLEN-1:PG_OFF];
    shiftAmt = 6'(lvlQ) * 6'(idxBits);
    idxMask  = (VPN_W'(1) << idxBits) - VPN_W'(1);
    idx      = (vpn >> shiftAmt) & idxMask;
    memAddr  = baseQ + (PA_W'(idx) << (sv32 ? 2 : 3));
    memWide  = !sv32;

    pteData  = sv32 ? PTE_W'(pteQ[31:0]) : pteQ;
    ppn      = pteData[10 +: PPN_W];
    {fD, fA, fU, fX, fW, fR, fV} = {pteData[7:6], pteData[4:0]};
    lowMask  = (PPN_W'(1) << shiftAmt) - PPN_W'(1);
    leafPa   = {ppn | (PPN_W'(vpn) & lowMask), vaQ[PG_OFF-1:0]};

    isStore  = (accQ == ACC_STORE);
    isFetch  = (accQ == ACC_FETCH);
    isLoad   = !isStore && !isFetch;

    misaligned = |(ppn & lowMask);
    uBad     = fU && (privQ != 2'd0) && (!sumQ || isFetch);
    sBad     = !fU && (privQ != 2'd1);
    accBad   = (isLoad && !(fR || (fX && mxrQ))) || (isStore && !fW) || (isFetch && !fX);
    leafBad  = (fW && !fR) || uBad || sBad || misaligned || accBad;

    pteNew   = pteQ | PTE_W'(8'h40) | (isStore ? PTE_W'(8'h80) : '0);
    memWdata = pteNew;

    sts.passThru  = (modeQ == MODE_BARE) || privQ[1];
    sts.badReq    = (levels == 3'd0) || (!sv32 && !canon);
    sts.isPtr     = fV && !fR && !fW && !fX;
    sts.pteFault  = !fV || (!sts.isPtr && leafBad);
    sts.lastLevel = (lvlQ == 3'd0);
    sts.needWrite = !fA || (isStore && !fD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaQ <= '0; accQ <= '0; privQ <= '0; sumQ <= 1'b0; mxrQ <= 1'b0;
      modeQ <= '0; lvlQ <= '0; baseQ <= '0; pteQ <= '0;
    end else begin
      if (stb.latchReq) begin
        vaQ   <= reqVa;
        accQ  <= reqAcc;
        privQ <= reqPriv;
        sumQ  <= reqSum;
        mxrQ  <= reqMxr;
        modeQ <= reqMode;
        lvlQ  <= modeDepth(reqMode) - 3'd1;
        baseQ <= {reqRootPpn, {PG_OFF{1'b0}}};
      end
      if (stb.latchPte) pteQ <= memRspData;
      if (stb.descend) begin
        baseQ <= {ppn, {PG_OFF{1'b0}}};
        lvlQ  <= lvlQ - 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneFault <= 1'b0; donePa <= '0;
      doneR <= 1'b0; doneW <= 1'b0; doneX <= 1'b0;
    end else if (stb.finBare) begin
      doneFault <= 1'b0; donePa <= vaQ[PA_W-1:0];
      doneR <= 1'b1; doneW <= 1'b1; doneX <= 1'b1;
    end else if (stb.finOk) begin
      doneFault <= 1'b0; donePa <= leafPa;
      doneR <= fR || (fX && mxrQ);
      doneW <= fW && (isStore || fD);
      doneX <= fX;
    end else if (stb.finFault) begin
      doneFault <= 1'b1; donePa <= '0;
      doneR <= 1'b0; doneW <= 1'b0; doneX <= 1'b0;
    end
  end
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  walkStatus_t sts,
  input  logic        memRspValid,
  input  logic        memRspErr,
  output walkStrobe_t stb,
  output logic        reqReady,
  output logic        doneValid,
  output logic        memReqValid,
  output logic        memReqWrite
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_READ, ST_RWAIT, ST_EVAL, ST_WRITE, ST_WWAIT, ST_DONE
  } walkState_t;

  walkState_t state, nextState;

  always_comb begin
    nextState = state;
    stb       = '0;
    case (state)
      ST_IDLE: if (reqValid) begin
        stb.latchReq = 1'b1;
        nextState    = ST_CHECK;
      end
      ST_CHECK: begin
        if (sts.passThru) begin
          stb.finBare = 1'b1; nextState = ST_DONE;
        end else if (sts.badReq) begin
          stb.finFault = 1'b1; nextState = ST_DONE;
        end else begin
          nextState = ST_READ;
        end
      end
      ST_READ: nextState = ST_RWAIT;
      ST_RWAIT: if (memRspValid) begin
        if (memRspErr) begin
          stb.finFault = 1'b1; nextState = ST_DONE;
        end else begin
          stb.latchPte = 1'b1; nextState = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (sts.pteFault) begin
          stb.finFault = 1'b1; nextState = ST_DONE;
        end else if (sts.isPtr) begin
          if (sts.lastLevel) begin
            stb.finFault = 1'b1; nextState = ST_DONE;
          end else begin
            stb.descend = 1'b1; nextState = ST_READ;
          end
        end else if (sts.needWrite) begin
          nextState = ST_WRITE;
        end else begin
          stb.finOk = 1'b1; nextState = ST_DONE;
        end
      end
      ST_WRITE: nextState = ST_WWAIT;
      ST_WWAIT: if (memRspValid) begin
        if (memRspErr) stb.finFault = 1'b1;
        else           stb.finOk    = 1'b1;
        nextState = ST_DONE;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  assign reqReady    = (state == ST_IDLE);
  assign doneValid   = (state == ST_DONE);
  assign memReqValid = (state == ST_READ) || (state == ST_WRITE);
  assign memReqWrite = (state == ST_WRITE);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int PA_W = 56
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [XLEN-1:0]        reqVa,
  input  logic [1:0]             reqAcc,
  input  logic [1:0]             reqPriv,
  input  logic                   reqSum,
  input  logic                   reqMxr,
  input  logic [2:0]             reqMode,
  input  logic [PA_W-13:0]       reqRootPpn,
  output logic                   doneValid,
  output logic                   doneFault,
  output logic [PA_W-1:0]        donePa,
  output logic                   doneR,
  output logic                   doneW,
  output logic                   doneX,
  output logic                   memReqValid,
  output logic                   memReqWrite,
  output logic                   memWide,
  output logic [PA_W-1:0]        memAddr,
  output logic [63:0]            memWdata,
  input  logic                   memRspValid,
  input  logic                   memRspErr,
  input  logic [63:0]            memRspData
);
  walkStrobe_t stb;
  walkStatus_t sts;

  pgwalk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .sts(sts),
    .memRspValid(memRspValid), .memRspErr(memRspErr), .stb(stb),
    .reqReady(reqReady), .doneValid(doneValid),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite)
  );

  pgwalk_dpath #(.XLEN(XLEN), .PA_W(PA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .reqVa(reqVa), .reqAcc(reqAcc), .reqPriv(reqPriv), .reqSum(reqSum),
    .reqMxr(reqMxr), .reqMode(reqMode), .reqRootPpn(reqRootPpn),
    .memRspData(memRspData), .sts(sts), .memAddr(memAddr),
    .memWdata(memWdata), .memWide(memWide), .doneFault(doneFault),
    .donePa(donePa), .doneR(doneR), .doneW(doneW), .doneX(doneX)
  );
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int XLEN = 64,
  parameter int PA_W = 56
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reqValid,
  input logic                   reqReady,
  input logic [XLEN-1:0]        reqVa,
  input logic [1:0]             reqAcc,
  input logic [1:0]             reqPriv,
  input logic                   reqSum,
  input logic                   reqMxr,
  input logic [2:0]             reqMode,
  input logic [PA_W-13:0]       reqRootPpn,
  input logic                   doneValid,
  input logic                   doneFault,
  input logic [PA_W-1:0]        donePa,
  input logic                   doneR,
  input logic                   doneW,
  input logic                   doneX,
  input logic                   memReqValid,
  input logic                   memReqWrite,
  input logic                   memWide,
  input logic [PA_W-1:0]        memAddr,
  input logic [63:0]            memWdata,
  input logic                   memRspValid,
  input logic                   memRspErr,
  input logic [63:0]            memRspData
);
  a_r13_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |=> !memReqValid);

  a_r13_busy_when_access: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |-> !reqReady);

  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> (!doneValid && reqReady));

  a_r13_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (doneValid && doneFault) |-> (donePa == '0 && !doneR && !doneW && !doneX));

  a_r2_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |-> (memWide ? (memAddr[2:0] == 3'd0) : (memAddr[1:0] == 2'd0)));

  a_r9_writeback_sets_a: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && memReqWrite) |-> memWdata[6]);

  a_r11_write_implies_read: assert property (@(posedge clk) disable iff (!rst_n)
    (doneValid && !doneFault && doneW) |-> doneR);
endmodule

bind pgwalk_top pgwalk_chk #(.XLEN(XLEN), .PA_W(PA_W)) u_chk (.*);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  acc;
    logic [1:0]  priv;
    logic        sum;
    logic        mxr;
    logic [2:0]  mode;
    logic [43:0] root;
    logic        fault;
    logic [55:0] pa;
    logic [2:0]  perm;   // {R,W,X}
    logic [3:0]  reads;
    logic [3:0]  writes;
    logic [3:0]  req;
  } vec_t;

  // acc: 0 fetch 1 load 2 store; priv: 0 U 1 S 3 M; mode: 0 bare 1..4, 5 invalid
  localparam vec_t VECS [32] = '{
    '{64'h0abc,              2'd1,2'd1,1'b0,1'b0,3'd2,44'd1,1'b0,56'h12345abc, 3'b110,4'd3,4'd0,4'd2},  // R2 4K walk
    '{64'h1010,              2'd2,2'd1,1'b0,1'b0,3'd2,44'd1,1'b0,56'h22222010, 3'b110,4'd3,4'd1,4'd9},  // R9 A+D wb
    '{64'h2020,              2'd0,2'd1,1'b0,1'b0,3'd2,44'd1,1'b0,56'h3020,     3'b001,4'd3,4'd0,4'd8},  // R8 fetch X
    '{64'h2020,              2'd1,2'd1,1'b0,1'b1,3'd2,44'd1,1'b0,56'h3020,     3'b101,4'd3,4'd0,4'd11}, // R11 mxr
    '{64'h2020,              2'd1,2'd1,1'b0,1'b0,3'd2,44'd1,1'b1,56'h0,        3'b000,4'd3,4'd0,4'd8},  // R8 load X only
    '{64'h3000,              2'd1,2'd1,1'b0,1'b0,3'd2,44'd1,1'b1,56'h0,        3'b000,4'd3,4'd0,4'd6},  // R6 sum=0
    '{64'h3004,              2'd1,2'd1,1'b1,1'b0,3'd2,44'd1,1'b0,56'h5004,     3'b111,4'd3,4'd0,4'd6},  // R6 sum=1
    '{64'h3000,              2'd0,2'd1,1'b1,1'b0,3'd2,44'd1,1'b1,56'h0,        3'b000,4'd3,4'd0,4'd6},  // R6 fetch U
    '{64'h3008,              2'd1,2'd0,1'b0,1'b0,3'd2,44'd1,1'b0,56'h5008,     3'b111,4'd3,4'd0,4'd6},  // R6 user ok
    '{64'h4000,              2'd1,2'd1,1'b0,1'b0,3'd2,44'd1,1'b1,56'h0,        3'b000,4'd3,4'd0,4'd4},  // R4 V clear
    '{64'h5000,              2'd1,2'd1,1'b0,1'b0,3'd2,44'd1,1'b1,56'h0,        3'b000,4'd3,4'd0,4'd5},  // R5 W only
    '{64'h6000,              2'd1,2'd1,1'b0,1'b0,3'd2,44'd1,1'b1,56'h0,        3'b000,4'd3,4'd0,4'd5},  // R5 W+X
    '{64'h7000,              2'd1,2'd1,1'b0,1'b0,3'd2,44'd1,1'b1,56'h0,        3'b000,4'd3,4'd0,4'd4},  // R4 ptr at last
    '{64'h8000,              2'd1,2'd0,1'b0,1'b0,3'd2,44'd1,1'b1,56'h0,        3'b000,4'd3,4'd0,4'd6},  // R6 S page from U
    '{64'h9000,              2'd1,2'd1,1'b0,1'b0,3'd2,44'd1,1'b0,56'h7000,     3'b100,4'd3,4'd1,4'd9},  // R9 A only wb
    '{64'h40123456,          2'd1,2'd1,1'b0,1'b0,3'd2,44'd1,1'b0,56'h80123456, 3'b111,4'd1,4'd0,4'd10}, // R10 1G page
    '{64'h80000000,          2'd1,2'd1,1'b0,1'b0,3'd2,44'd1,1'b1,56'h0,        3'b000,4'd1,4'd0,4'd7},  // R7 misaligned
    '{64'hC0000000,          2'd1,2'd1,1'b0,1'b0,3'd2,44'd1,1'b1,56'h0,        3'b000,4'd2,4'd0,4'd12}, // R12 bus error
    '{64'h234567,            2'd1,2'd1,1'b0,1'b0,3'd2,44'd1,1'b0,56'h434567,   3'b100,4'd2,4'd0,4'd10}, // R10 2M page
    '{64'h234567,            2'd2,2'd1,1'b0,1'b0,3'd2,44'd1,1'b1,56'h0,        3'b000,4'd2,4'd0,4'd8},  // R8 store no W
    '{64'h0000008000000000,  2'd1,2'd1,1'b0,1'b0,3'd2,44'd1,1'b1,56'h0,        3'b000,4'd0,4'd0,4'd3},  // R3 noncanonical
    '{64'hFFFFFFC000000010,  2'd1,2'd1,1'b0,1'b0,3'd2,44'd1,1'b0,56'hC0000010, 3'b100,4'd1,4'd0,4'd3},  // R3 negative ok
    '{64'h456789,            2'd1,2'd1,1'b0,1'b0,3'd1,44'd4,1'b0,56'hC56789,   3'b111,4'd1,4'd0,4'd10}, // R10 4M page
    '{64'h800000,            2'd1,2'd1,1'b0,1'b0,3'd1,44'd4,1'b1,56'h0,        3'b000,4'd1,4'd0,4'd7},  // R7 2-level
    '{64'h3123,              2'd1,2'd1,1'b0,1'b0,3'd1,44'd4,1'b0,56'h2ABCDE123,3'b100,4'd2,4'd0,4'd2},  // R2 2-level 4K
    '{64'hFFFFFFFF00003123,  2'd1,2'd1,1'b0,1'b0,3'd1,44'd4,1'b0,56'h2ABCDE123,3'b100,4'd2,4'd0,4'd3},  // R3 upper ignored
    '{64'h40123456,          2'd1,2'd1,1'b0,1'b0,3'd3,44'd6,1'b0,56'h80123456, 3'b111,4'd2,4'd0,4'd2},  // R2 4-level
    '{64'h0001000000000000,  2'd1,2'd1,1'b0,1'b0,3'd3,44'd6,1'b1,56'h0,        3'b000,4'd0,4'd0,4'd3},  // R3 4-level
    '{64'h40123456,          2'd1,2'd1,1'b0,1'b0,3'd4,44'd7,1'b0,56'h80123456, 3'b111,4'd3,4'd0,4'd2},  // R2 5-level
    '{64'h123456789abc,      2'd2,2'd1,1'b0,1'b0,3'd0,44'd1,1'b0,56'h123456789abc,3'b111,4'd0,4'd0,4'd1}, // R1 bare
    '{64'hDEADBEEF,          2'd1,2'd3,1'b0,1'b0,3'd2,44'd1,1'b0,56'hDEADBEEF, 3'b111,4'd0,4'd0,4'd1},  // R1 machine
    '{64'h1000,              2'd1,2'd1,1'b0,1'b0,3'd5,44'd1,1'b1,56'h0,        3'b000,4'd0,4'd0,4'd2}   // R2 bad mode
  };

  localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                         FU = 8'h10, FA = 8'h40, FD = 8'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqVa = '0;
  logic [1:0]  reqAcc = '0, reqPriv = '0;
  logic        reqSum = 1'b0, reqMxr = 1'b0;
  logic [2:0]  reqMode = '0;
  logic [43:0] reqRootPpn = '0;
  logic        doneValid, doneFault, doneR, doneW, doneX;
  logic [55:0] donePa;
  logic        memReqValid, memReqWrite, memWide;
  logic [55:0] memAddr;
  logic [63:0] memWdata;
  logic        memRspValid = 1'b0, memRspErr = 1'b0;
  logic [63:0] memRspData = '0;

  logic [63:0] mem [4096];
  int nRd = 0, nWr = 0;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwalk_top u_dut (.*);

  // behavioural memory: one-cycle response, pages 0..7 backed, above 0x7FFF errors
  always @(posedge clk) begin
    memRspValid <= 1'b0;
    memRspErr   <= 1'b0;
    if (memReqValid) begin
      memRspValid <= 1'b1;
      if (memReqWrite) nWr <= nWr + 1; else nRd <= nRd + 1;
      if (memAddr[55:15] != '0) begin
        memRspErr  <= 1'b1;
        memRspData <= '0;
      end else if (memReqWrite) begin
        if (memWide) mem[{memAddr[14:12], memAddr[11:3]}] <= memWdata;
        else if (memAddr[2]) mem[{memAddr[14:12], memAddr[11:3]}][63:32] <= memWdata[31:0];
        else mem[{memAddr[14:12], memAddr[11:3]}][31:0] <= memWdata[31:0];
      end else begin
        if (memWide) memRspData <= mem[{memAddr[14:12], memAddr[11:3]}];
        else if (memAddr[2]) memRspData <= {32'b0, mem[{memAddr[14:12], memAddr[11:3]}][63:32]};
        else memRspData <= {32'b0, mem[{memAddr[14:12], memAddr[11:3]}][31:0]};
      end
    end
  end

  function automatic logic [63:0] mkPte(input logic [43:0] ppn, input logic [7:0] fl);
    return (64'(ppn) << 10) | 64'(fl);
  endfunction

  task automatic put64(input int page, input int idx, input logic [63:0] v);
    mem[{page[2:0], idx[8:0]}] = v;
  endtask

  task automatic put32(input int page, input int idx, input logic [63:0] v);
    if (idx[0]) mem[{page[2:0], idx[9:1]}][63:32] = v[31:0];
    else        mem[{page[2:0], idx[9:1]}][31:0]  = v[31:0];
  endtask

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic walk(input vec_t v);
    int cyc;
    @(negedge clk);
    nRd = 0; nWr = 0;
    reqValid = 1'b1; reqVa = v.va; reqAcc = v.acc; reqPriv = v.priv;
    reqSum = v.sum; reqMxr = v.mxr; reqMode = v.mode; reqRootPpn = v.root;
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0;
    while (!doneValid && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(doneValid, 13, "completion", 64'(doneValid), 64'd1);
    chk(doneFault == v.fault, int'(v.req), "fault", 64'(doneFault), 64'(v.fault));
    chk(donePa == v.pa, int'(v.req), "pa", 64'(donePa), 64'(v.pa));
    chk({doneR, doneW, doneX} == v.perm, int'(v.req), "perm", 64'({doneR, doneW, doneX}), 64'(v.perm));
    chk(nRd == int'(v.reads), int'(v.req), "reads", 64'(nRd), 64'(v.reads));
    chk(nWr == int'(v.writes), int'(v.req), "writes", 64'(nWr), 64'(v.writes));
    @(negedge clk);
    chk(!doneValid && reqReady, 13, "done pulse", 64'({doneValid, reqReady}), 64'b01); // R13
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    // 3-level root (page 1), also level-2 table for 4/5-level modes
    put64(1, 0,   mkPte(44'd2, FV));
    put64(1, 1,   mkPte(44'h80000, FV|FR|FW|FX|FA|FD));
    put64(1, 2,   mkPte(44'h80001, FV|FR|FW|FX|FA|FD));
    put64(1, 3,   mkPte(44'h10, FV));
    put64(1, 256, mkPte(44'hC0000, FV|FR|FA));
    put64(2, 0,   mkPte(44'd3, FV));
    put64(2, 1,   mkPte(44'h400, FV|FR|FA));
    put64(3, 0,   mkPte(44'h12345, FV|FR|FW|FA|FD));
    put64(3, 1,   mkPte(44'h22222, FV|FR|FW));
    put64(3, 2,   mkPte(44'h3, FV|FX|FA));
    put64(3, 3,   mkPte(44'h5, FV|FR|FW|FX|FU|FA|FD));
    put64(3, 4,   mkPte(44'h9, FR|FA));
    put64(3, 5,   mkPte(44'h9, FV|FW|FA));
    put64(3, 6,   mkPte(44'h9, FV|FW|FX|FA));
    put64(3, 7,   mkPte(44'h2, FV));
    put64(3, 8,   mkPte(44'h7, FV|FR|FA));
    put64(3, 9,   mkPte(44'h7, FV|FR));
    put64(6, 0,   mkPte(44'd1, FV));
    put64(7, 0,   mkPte(44'd6, FV));
    // 2-level tables: root page 4, leaf table page 5
    put32(4, 0, mkPte(44'd5, FV));
    put32(4, 1, mkPte(44'hC00, FV|FR|FW|FX|FA|FD));
    put32(4, 2, mkPte(44'h401, FV|FR|FW|FX|FA|FD));
    put32(5, 3, mkPte(44'h2ABCDE, FV|FR|FA));

    repeat (3) @(negedge clk);
    // R13 reset state
    chk(reqReady == 1'b1, 13, "reset ready", 64'(reqReady), 64'd1);
    chk(!doneValid && !memReqValid, 13, "reset idle", 64'({doneValid, memReqValid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reqReady && !doneValid && !memReqValid, 13, "idle after reset",
        64'({reqReady, doneValid, memReqValid}), 64'b100);

    foreach (VECS[i]) walk(VECS[i]);

    // R9 write-back contents left in memory
    chk(mem[{3'd3, 9'd1}] == mkPte(44'h22222, FV|FR|FW|FA|FD), 9, "store wb",
        mem[{3'd3, 9'd1}], mkPte(44'h22222, FV|FR|FW|FA|FD));
    chk(mem[{3'd3, 9'd9}] == mkPte(44'h7, FV|FR|FA), 9, "load wb",
        mem[{3'd3, 9'd9}], mkPte(44'h7, FV|FR|FA));
    // R9 repeated accesses now need no write-back
    walk('{64'h9000, 2'd1, 2'd1, 1'b0, 1'b0, 3'd2, 44'd1, 1'b0, 56'h7000, 3'b100, 4'd3, 4'd0, 4'd9});
    walk('{64'h1010, 2'd2, 2'd1, 1'b0, 1'b0, 3'd2, 44'd1, 1'b0, 56'h22222010, 3'b110, 4'd3, 4'd0, 4'd9});
    // R11 store on a dirty page grants W, load on a clean W page does not
    put64(3, 10, mkPte(44'h8, FV|FR|FW|FA));
    walk('{64'hA000, 2'd1, 2'd1, 1'b0, 1'b0, 3'd2, 44'd1, 1'b0, 56'h8000, 3'b100, 4'd3, 4'd0, 4'd11});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R13 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule